// File: doc/BRIEF.md
# LPDDR Inter-Bank Command Spacing Checker

This block watches a stream of decoded SDRAM commands, one per clock at most, each with a bank address, an auto-precharge flag and a valid strobe. It does not drive the memory. It keeps a small model of every bank's state. It also remembers the most recent access that ended with auto precharge, and how long ago that access was issued. From this it finds commands that are issued too early or in an illegal state. Each such command raises a one-cycle violation pulse that carries a 3-bit cause vector.

The spacing that a command to another bank needs after an auto-precharge access depends on two things: whether that access was a read or a write, and whether the new command reads or writes. A refresh or a mode-register load is legal only while every bank is idle. A write that comes too soon after a read burst is flagged as data contention, unless a burst terminate has cut the burst short first.

Burst length, CAS latency, write-to-read delay, write recovery and precharge time are static inputs given in clock cycles. They are captured while reset is held. The checker keeps tracking commands after it flags one, so the checks that follow are based on a consistent state.

Top module: `lpddr_cmd_spacing_chk`

## Requirements
- R1: While `rst_n` is low the outputs are 0 and the block captures the configuration inputs. `cfg_bl_code` values 0, 1, 2 and 3 select burst lengths 2, 4, 8 and 16, so half the burst length (H) is 1, 2, 4 or 8. A change to a configuration input after reset has no effect.
- R2: After a write with auto precharge at cycle t, a read (with or without auto precharge) to a different bank at cycle t+k with k < 1 + H + tWTR sets code bit 0 (spacing).
- R3: After a write with auto precharge at cycle t, a write to a different bank with k < H sets code bit 0.
- R4: After a read with auto precharge at cycle t, a read to a different bank with k < H sets code bit 0.
- R5: After a read with auto precharge at cycle t, a write to a different bank with k < CL + H sets code bit 0.
- R6: Only the most recent auto-precharge access counts. Activate and precharge commands to other banks, and any command to that access's own bank, never set code bit 0.
- R7: A refresh or mode-register load while any bank is open or busy sets code bit 1 (bank state).
- R8: A read with auto precharge issued at cycle t makes its bank busy for cycles t+1 to t+H+tRP. A write with auto precharge makes its bank busy for cycles t+1 to t+1+H+tWR+tRP. A precharge of an open bank makes that bank busy for cycles t+1 to t+tRP. A read, write or precharge to a busy bank, or an activate to a bank that is open or busy, sets code bit 1.
- R9: A write issued fewer than CL+H cycles after the latest read (with or without auto precharge), with no burst terminate in between, sets code bit 2 (contention).
- R10: `cmd_op` is encoded as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-register load and 7 burst terminate. The code for a command at cycle t appears on `viol_code` in cycle t+1. `viol` is high exactly when that code is nonzero, and never follows a cycle in which `cmd_vld` is low.
- R11: A command that sets code bit 1 leaves its bank's state unchanged. The auto-precharge and read-burst trackers still take every command into account, whether or not it is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cfg_bl_code | input | 2 | Burst length select (2/4/8/16) |
| cfg_cas | input | TW | CAS latency in cycles |
| cfg_wtr | input | TW | Write-to-read delay in cycles |
| cfg_wrec | input | TW | Write recovery in cycles |
| cfg_prech | input | TW | Precharge time in cycles |
| cmd_vld | input | 1 | Command valid this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_ap | input | 1 | Auto precharge flag for read or write |
| cmd_bank | input | log2(NB) | Target bank |
| viol | output | 1 | Violation pulse, one cycle after the command |
| viol_code | output | 3 | Cause vector: bit 0 spacing, bit 1 bank state, bit 2 contention |

## Verification
The hardest case to reach from the ports needs three conditions together. A command must land exactly on the boundary cycle of a spacing window. It must go to a bank other than the one that issued the auto-precharge access. And the target bank must be open and not busy, so that no other rule also fires. Random traffic seldom lines these up. The bench therefore starts each directed scenario from a fresh reset, opens two banks, issues the auto-precharge access and pads with a counted run of no-ops, so that the following read or write falls one cycle before the limit and then on it. A long random phase with frequent no-ops then mixes the spacing, bank-state and contention rules under two further configurations, checked against a cycle model kept in the bench.

// File: rtl/lpddr_cmd_spacing_chk.sv
`timescale 1ns/1ps
module lpddr_cmd_spacing_chk #(
  parameter int NB = 4,
  parameter int TW = 6,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_bl_code,
  input  logic [TW-1:0] cfg_cas,
  input  logic [TW-1:0] cfg_wtr,
  input  logic [TW-1:0] cfg_wrec,
  input  logic [TW-1:0] cfg_prech,
  input  logic          cmd_vld,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_ap,
  input  logic [BW-1:0] cmd_bank,
  output logic          viol,
  output logic [2:0]    viol_code
);
  localparam int CW = TW + 3;
  localparam logic [CW-1:0] AGE_MAX = '1;
  localparam logic [2:0] OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                         OP_PRE = 3'd4, OP_REF = 3'd5, OP_LMR = 3'd6,
                         OP_BST = 3'd7;

  logic [1:0]    bl_q;
  logic [TW-1:0] cas_q, wtr_q, wrec_q, prech_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      bl_q    <= cfg_bl_code;
      cas_q   <= cfg_cas;
      wtr_q   <= cfg_wtr;
      wrec_q  <= cfg_wrec;
      prech_q <= cfg_prech;
    end

  wire [CW-1:0] half   = CW'(1) << bl_q;
  wire [CW-1:0] t_rp   = CW'(prech_q);
  wire [CW-1:0] n_rda  = half + t_rp;
  wire [CW-1:0] n_wra  = CW'(1) + half + CW'(wrec_q) + t_rp;
  wire [CW-1:0] rd_win = CW'(cas_q) + half - CW'(1);

  wire is_act = cmd_vld && cmd_op == OP_ACT;
  wire is_rd  = cmd_vld && cmd_op == OP_RD;
  wire is_wr  = cmd_vld && cmd_op == OP_WR;
  wire is_pre = cmd_vld && cmd_op == OP_PRE;
  wire is_all = cmd_vld && (cmd_op == OP_REF || cmd_op == OP_LMR);
  wire is_bst = cmd_vld && cmd_op == OP_BST;
  wire is_apx = (is_rd || is_wr) && cmd_ap;

  logic [NB-1:0] open_q;
  logic [CW-1:0] cnt_q [NB];
  logic [NB-1:0] busy;
  logic          ap_vld, ap_wr;
  logic [BW-1:0] ap_bank;
  logic [CW-1:0] ap_age, rd_left, need;

  always_comb
    for (int k = 0; k < NB; k++) busy[k] = cnt_q[k] != '0;

  wire sel_busy = busy[cmd_bank];
  wire sel_open = open_q[cmd_bank];
  wire bank_err = (is_act && (sel_open || sel_busy)) ||
                  ((is_rd || is_wr || is_pre) && sel_busy) ||
                  (is_all && (|busy || |open_q));

  always_comb begin
    if (ap_wr) need = is_rd ? CW'(1) + half + CW'(wtr_q) : half;
    else       need = is_rd ? half : CW'(cas_q) + half;
  end

  wire space_err = (is_rd || is_wr) && ap_vld && cmd_bank != ap_bank && ap_age < need;
  wire cont_err  = is_wr && rd_left != '0;
  wire [2:0] code = {cont_err, bank_err, space_err};

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit = cmd_vld && cmd_bank == BW'(i) && !bank_err;
    always_ff @(posedge clk)
      if (!rst_n) begin
        open_q[i] <= 1'b0;
        cnt_q[i]  <= '0;
      end else if (hit && is_act) begin
        open_q[i] <= 1'b1;
      end else if (hit && is_apx) begin
        open_q[i] <= 1'b0;
        cnt_q[i]  <= is_rd ? n_rda : n_wra;
      end else if (hit && is_pre && open_q[i]) begin
        open_q[i] <= 1'b0;
        cnt_q[i]  <= t_rp;
      end else if (busy[i]) begin
        cnt_q[i]  <= cnt_q[i] - CW'(1);
      end

    // R8
    bank_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && !(cmd_vld && cmd_bank == BW'(i)) |=> cnt_q[i] == $past(cnt_q[i]) - CW'(1));
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      ap_vld  <= 1'b0;
      ap_wr   <= 1'b0;
      ap_bank <= '0;
      ap_age  <= '0;
    end else if (is_apx) begin
      ap_vld  <= 1'b1;
      ap_wr   <= is_wr;
      ap_bank <= cmd_bank;
      ap_age  <= CW'(1);
    end else if (ap_age != AGE_MAX) begin
      ap_age  <= ap_age + CW'(1);
    end

  always_ff @(posedge clk)
    if (!rst_n)                rd_left <= '0;
    else if (is_rd)            rd_left <= rd_win;
    else if (is_bst)           rd_left <= '0;
    else if (rd_left != '0)    rd_left <= rd_left - CW'(1);

  always_ff @(posedge clk)
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      viol      <= |code;
      viol_code <= code;
    end

  // R2
  ap_age_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_apx |=> ap_vld && ap_age == CW'(1) && ap_bank == $past(cmd_bank));

  // R9
  bst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_bst |=> rd_left == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !viol && viol_code == 3'b000);
endmodule

// File: tb/test_lpddr_cmd_spacing_chk.sv
`timescale 1ns/1ps
module test_lpddr_cmd_spacing_chk;
  localparam int NB = 4, TW = 6, AMAX = 511;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, LMR = 6, BST = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_bl_code = 0;
  logic [TW-1:0] cfg_cas = 0, cfg_wtr = 0, cfg_wrec = 0, cfg_prech = 0;
  logic cmd_vld = 0, cmd_ap = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_bank = 0;
  logic viol;
  logic [2:0] viol_code;

  int checks = 0, errors = 0;
  int m_half, m_cl, m_wtr, m_wr, m_rp;
  int m_open[NB], m_cnt[NB];
  int m_apv, m_apw, m_apb, m_age, m_rdl;

  always #5 clk = ~clk;

  lpddr_cmd_spacing_chk #(.NB(NB), .TW(TW)) i_lpddr_cmd_spacing_chk (
    .clk, .rst_n, .cfg_bl_code, .cfg_cas, .cfg_wtr, .cfg_wrec, .cfg_prech,
    .cmd_vld, .cmd_op, .cmd_ap, .cmd_bank, .viol, .viol_code);

  function automatic logic [2:0] model_code(bit v, int op, bit ap, int b);
    logic [2:0] c = 3'b000;
    bit anyb = 0;
    int need;
    if (!v) return c;
    for (int k = 0; k < NB; k++) if (m_open[k] != 0 || m_cnt[k] != 0) anyb = 1;
    if (op == ACT && (m_open[b] != 0 || m_cnt[b] != 0)) c[1] = 1;
    if ((op == RD || op == WR || op == PRE) && m_cnt[b] != 0) c[1] = 1;
    if ((op == REF || op == LMR) && anyb) c[1] = 1;
    if (m_apw != 0) need = (op == RD) ? 1 + m_half + m_wtr : m_half;
    else            need = (op == RD) ? m_half : m_cl + m_half;
    if ((op == RD || op == WR) && m_apv != 0 && b != m_apb && m_age < need) c[0] = 1;
    if (op == WR && m_rdl != 0) c[2] = 1;
    return c;
  endfunction

  task automatic model_step(bit v, int op, bit ap, int b, logic [2:0] c);
    bit apx = v && (op == RD || op == WR) && ap;
    for (int k = 0; k < NB; k++) begin
      bit hit = v && k == b && !c[1];
      if (hit && op == ACT) m_open[k] = 1;
      else if (hit && apx) begin
        m_open[k] = 0;
        m_cnt[k] = (op == RD) ? m_half + m_rp : 1 + m_half + m_wr + m_rp;
      end else if (hit && op == PRE && m_open[k] != 0) begin
        m_open[k] = 0;
        m_cnt[k] = m_rp;
      end else if (m_cnt[k] > 0) m_cnt[k]--;
    end
    if (apx) begin
      m_apv = 1; m_apw = (op == WR); m_apb = b; m_age = 1;
    end else if (m_age < AMAX) m_age++;
    if (v && op == RD) m_rdl = m_cl + m_half - 1;
    else if (v && op == BST) m_rdl = 0;
    else if (m_rdl > 0) m_rdl--;
  endtask

  task automatic issue(bit v, int op, bit ap, int b, string tag);
    logic [2:0] e = model_code(v, op, ap, b);
    @(negedge clk);
    cmd_vld = v; cmd_op = 3'(op); cmd_ap = ap; cmd_bank = 2'(b);
    @(posedge clk);
    #1;
    checks++;
    if (viol !== (e != 0) || viol_code !== e) begin
      errors++;
      $display("FAIL %s: viol=%0d code=%b expected viol=%0d code=%b", tag, viol, viol_code, e != 0, e);
    end
    model_step(v, op, ap, b, e);
  endtask

  task automatic nops(int n, string tag);
    for (int i = 0; i < n; i++) issue(0, NOP, 0, 0, tag);
  endtask

  task automatic do_reset(int bl, int cl, int wtr, int wr, int rp);
    @(negedge clk);
    rst_n = 0; cmd_vld = 0;
    cfg_bl_code = 2'(bl); cfg_cas = TW'(cl); cfg_wtr = TW'(wtr); cfg_wrec = TW'(wr); cfg_prech = TW'(rp);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_half = 1 << bl; m_cl = cl; m_wtr = wtr; m_wr = wr; m_rp = rp;
    for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_cnt[k] = 0; end
    m_apv = 0; m_apw = 0; m_apb = 0; m_age = 0; m_rdl = 0;
  endtask

  initial begin : watchdog
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    // R1: reset state
    do_reset(2, 3, 2, 3, 3);
    #1;
    checks++;
    if (viol !== 1'b0 || viol_code !== 3'b000) begin
      errors++;
      $display("FAIL R1: viol=%0d code=%b expected viol=0 code=000", viol, viol_code);
    end
    // R2: write-AP then read to other bank, boundary at 1+4+2=7
    issue(1, ACT, 0, 0, "R8 act"); issue(1, ACT, 0, 1, "R8 act");
    issue(1, WR, 1, 0, "R2 wra");
    nops(5, "R10 idle");
    issue(1, RD, 0, 1, "R2 early read");
    issue(1, RD, 0, 1, "R2 read on limit");
    issue(1, RD, 0, 0, "R8 read busy bank");
    // R3
    do_reset(2, 3, 2, 3, 3);
    issue(1, ACT, 0, 0, "R8 act"); issue(1, ACT, 0, 1, "R8 act");
    issue(1, WR, 1, 0, "R3 wra");
    nops(2, "R10 idle");
    issue(1, WR, 0, 1, "R3 early write");
    issue(1, WR, 1, 1, "R3 write on limit");
    issue(1, WR, 0, 0, "R6 same bank write");
    // R4 R5 R9
    do_reset(2, 3, 2, 3, 3);
    issue(1, ACT, 0, 0, "R8 act"); issue(1, ACT, 0, 1, "R8 act");
    issue(1, RD, 1, 0, "R4 rda");
    nops(1, "R10 idle");
    issue(1, RD, 0, 1, "R4 early read");
    issue(1, RD, 0, 1, "R4 early read");
    issue(1, RD, 0, 1, "R4 read on limit");
    issue(1, WR, 0, 1, "R5 R9 early write");
    issue(1, BST, 0, 1, "R9 terminate");
    issue(1, WR, 0, 1, "R5 R9 write after terminate");
    // R6
    do_reset(2, 3, 2, 3, 3);
    issue(1, ACT, 0, 0, "R8 act");
    issue(1, RD, 1, 0, "R6 rda");
    issue(1, ACT, 0, 1, "R6 act other bank");
    issue(1, PRE, 0, 1, "R6 pre other bank");
    // R7 R8 R11
    do_reset(2, 3, 2, 3, 3);
    issue(1, ACT, 0, 0, "R8 act");
    issue(1, ACT, 0, 0, "R8 act open bank");
    issue(1, REF, 0, 0, "R7 refresh open");
    issue(1, PRE, 0, 0, "R8 pre");
    issue(1, ACT, 0, 0, "R8 R11 act busy");
    issue(1, LMR, 0, 0, "R7 lmr busy");
    issue(1, PRE, 0, 0, "R8 pre busy");
    issue(1, REF, 0, 0, "R7 refresh idle");
    issue(1, LMR, 0, 0, "R7 lmr idle");
    issue(1, ACT, 0, 0, "R11 act after idle");
    // R1: configuration change after reset is ignored
    do_reset(2, 3, 2, 3, 3);
    @(negedge clk);
    cfg_bl_code = 2'd0; cfg_cas = TW'(1); cfg_wtr = TW'(0); cfg_wrec = TW'(0); cfg_prech = TW'(0);
    issue(1, ACT, 0, 0, "R1 act"); issue(1, ACT, 0, 1, "R1 act");
    issue(1, WR, 1, 0, "R1 wra");
    nops(2, "R1 idle");
    issue(1, RD, 0, 1, "R1 old config still applies");
    // random phases
    do_reset(3, 2, 1, 2, 2);
    for (int n = 0; n < 5000; n++) begin
      int r = $urandom_range(0, 15);
      int op; bit v;
      v = r >= 4;
      op = (r < 4) ? NOP : (r < 6) ? ACT : (r < 8) ? RD : (r < 10) ? WR :
           (r < 12) ? PRE : (r == 12) ? REF : (r == 13) ? LMR : (r == 14) ? BST : NOP;
      issue(v, op, 1'($urandom_range(0, 1)), $urandom_range(0, NB - 1), "R10 random B");
    end
    do_reset(0, 1, 3, 1, 1);
    for (int n = 0; n < 5000; n++) begin
      int r = $urandom_range(0, 15);
      int op; bit v;
      v = r >= 4;
      op = (r < 4) ? NOP : (r < 6) ? ACT : (r < 8) ? RD : (r < 10) ? WR :
           (r < 12) ? PRE : (r == 12) ? REF : (r == 13) ? LMR : (r == 14) ? BST : NOP;
      issue(v, op, 1'($urandom_range(0, 1)), $urandom_range(0, NB - 1), "R10 random C");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule